// File: doc/BRIEF.md
# T1 Line Alarm Monitor (AIS and LOS)

This block watches the recovered serial data of a T1 line, one bit per strobe, and raises two alarms. The alarm-indication flag spots an unframed all-ones stream. It counts the zeros in consecutive fixed windows of 4632 bit periods, which is 3 ms at 1.544 Mb/s. At the end of each window it decides again: few zeros together with an asserted loss-of-frame qualifier sets the flag, and anything else clears it. Because of the qualifier, a framed all-ones payload never raises the alarm.

The loss-of-signal flag rises after a long run of consecutive zeros. Once it is raised, the block waits for the first one. From that one it opens a 112-bit span and checks the ones density over it. If enough ones arrive inside the span, the alarm clears. If the span runs out first, the check waits for the next one and starts again. Each alarm has a level output and two single-cycle event pulses, one for set and one for clear, so interrupt logic nearby can latch changes without finding the edges itself.

Top module: `t1_alarm_mon`

## Requirements
- R1: While reset is asserted, and after it is released, both alarm levels and all four event pulses are low.
- R2: The alarm-indication level changes only at the end of a window. The first window starts with the first strobed bit after reset, and each window covers exactly 4632 strobed bits.
- R3: A window holding 5 or fewer zeros sets the alarm-indication level at its last bit, provided the loss-of-frame qualifier (1 = frame lost) is high on that bit.
- R4: A window holding 6 or more zeros clears the alarm-indication level at its last bit.
- R5: A window that ends while the qualifier is low leaves the alarm-indication level at 0, whatever its zero count, and clears the level if it was set.
- R6: The loss-of-signal level rises on the 192nd consecutive strobed zero. A one anywhere in the run restarts the count, so 191 zeros followed by a one do not raise it.
- R7: While loss of signal is declared, the alarm clears on the bit that brings the ones count to 14 inside a 112-bit span. The span starts at the first one received and counts that one as its bit 1. A 14th one that lands on bit 112 still clears the alarm.
- R8: If a span ends with fewer than 14 ones, loss of signal stays declared. The ones counted in that span are discarded, and a new span opens at the next one.
- R9: Every set or clear pulse lasts exactly one cycle and appears in the same cycle as the level change it marks. A set pulse and a clear pulse of the same alarm never coincide.
- R10: A cycle with the bit strobe low counts as no bit at all. It changes neither alarm level nor any count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Strobe: bit_in holds a valid line bit this cycle |
| bit_in | input | 1 | Recovered line data bit |
| lof_in | input | 1 | Loss-of-frame qualifier, 1 = frame alignment lost |
| ais_o | output | 1 | Alarm-indication (unframed all-ones) level |
| ais_set_p | output | 1 | One-cycle pulse when ais_o rises |
| ais_clr_p | output | 1 | One-cycle pulse when ais_o falls |
| los_o | output | 1 | Loss-of-signal level |
| los_set_p | output | 1 | One-cycle pulse when los_o rises |
| los_clr_p | output | 1 | One-cycle pulse when los_o falls |

## Verification
Some properties are checked on every cycle. Each event pulse must line up with an edge of its alarm level, set and clear pulses must never coincide, both levels must hold on cycles without a strobe, and the outputs must be quiet while reset is asserted. The thresholds themselves can only be shown by the bench's scenarios: 5 against 6 zeros per window, the qualifier gating, 191 against 192 zeros, a 14th one arriving exactly on span bit 112, and a span that fails and is re-armed at a later one.

// File: rtl/t1_alarm_pkg.sv
package t1_alarm_pkg;

  // loss-of-signal tracker states
  typedef enum logic [1:0] {
    LS_CLEAR = 2'd0,  // no alarm, counting zero runs
    LS_ARMED = 2'd1,  // alarm declared, waiting for a one
    LS_SPAN  = 2'd2   // alarm declared, density span open
  } los_state_e;

  // bit periods in 3 ms at 1.544 Mb/s
  localparam int unsigned T1_WIN_BITS = 4632;

endpackage

// File: rtl/t1_rst_sync.sv
module t1_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/t1_ais_window.sv
module t1_ais_window #(
  parameter int unsigned WIN_BITS  = 4632,
  parameter int unsigned MAX_ZEROS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic qual_in,
  output logic ais_o,
  output logic set_p,
  output logic clr_p
);

  localparam int unsigned BW = $clog2(WIN_BITS);
  localparam int unsigned ZW = $clog2(MAX_ZEROS + 2);
  localparam logic [BW-1:0] WIN_LAST = BW'(WIN_BITS - 1);
  localparam logic [ZW-1:0] ZERO_SAT = ZW'(MAX_ZEROS + 1);
  localparam logic [ZW-1:0] ZERO_MAX = ZW'(MAX_ZEROS);

  logic [BW-1:0] pos_q,  pos_n;
  logic [ZW-1:0] zero_q, zero_n;
  logic [ZW-1:0] zero_now;
  logic          ais_q,  ais_n;
  logic          set_q,  set_n;
  logic          clr_q,  clr_n;
  logic          win_end;

  // zero count including the current bit, held at the saturation value
  always_comb begin
    if (!bit_in && (zero_q != ZERO_SAT)) begin
      zero_now = zero_q + ZW'(1);
    end else begin
      zero_now = zero_q;
    end
  end

  assign win_end = (pos_q == WIN_LAST);

  always_comb begin
    pos_n  = pos_q;
    zero_n = zero_q;
    ais_n  = ais_q;
    set_n  = 1'b0;
    clr_n  = 1'b0;
    if (bit_en) begin
      if (win_end) begin
        pos_n  = '0;
        zero_n = '0;
        ais_n  = (zero_now <= ZERO_MAX) && qual_in;
        set_n  = ais_n && !ais_q;
        clr_n  = !ais_n && ais_q;
      end else begin
        pos_n  = pos_q + BW'(1);
        zero_n = zero_now;
      end
    end
  end

  // window state advances only on strobed bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      zero_q <= '0;
      ais_q  <= 1'b0;
    end else if (bit_en) begin
      pos_q  <= pos_n;
      zero_q <= zero_n;
      ais_q  <= ais_n;
    end
  end

  // event pulses return to zero on every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      set_q <= set_n;
      clr_q <= clr_n;
    end
  end

  assign ais_o = ais_q;
  assign set_p = set_q;
  assign clr_p = clr_q;

endmodule

// File: rtl/t1_los_detect.sv
module t1_los_detect
  import t1_alarm_pkg::*;
#(
  parameter int unsigned ZERO_RUN  = 192,
  parameter int unsigned SPAN_BITS = 112,
  parameter int unsigned MIN_ONES  = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output logic los_o,
  output logic set_p,
  output logic clr_p
);

  localparam int unsigned RW = $clog2(ZERO_RUN);
  localparam int unsigned SW = $clog2(SPAN_BITS + 1);
  localparam int unsigned OW = $clog2(MIN_ONES + 1);
  localparam logic [RW-1:0] RUN_LAST  = RW'(ZERO_RUN - 1);
  localparam logic [SW-1:0] SPAN_LAST = SW'(SPAN_BITS - 1);
  localparam logic [OW-1:0] ONES_LAST = OW'(MIN_ONES - 1);

  los_state_e    state_q, state_n;
  logic [RW-1:0] run_q,   run_n;
  logic [SW-1:0] span_q,  span_n;
  logic [OW-1:0] ones_q,  ones_n;
  logic          set_q,   set_n;
  logic          clr_q,   clr_n;

  always_comb begin
    state_n = state_q;
    run_n   = run_q;
    span_n  = span_q;
    ones_n  = ones_q;
    set_n   = 1'b0;
    clr_n   = 1'b0;
    if (bit_en) begin
      unique case (state_q)
        LS_CLEAR: begin
          if (bit_in) begin
            run_n = '0;
          end else if (run_q == RUN_LAST) begin
            run_n   = '0;
            state_n = LS_ARMED;
            set_n   = 1'b1;
          end else begin
            run_n = run_q + RW'(1);
          end
        end
        LS_ARMED: begin
          // the span opens on the first one, which is its bit 1
          if (bit_in) begin
            span_n  = SW'(1);
            ones_n  = OW'(1);
            state_n = LS_SPAN;
          end
        end
        LS_SPAN: begin
          span_n = span_q + SW'(1);
          if (bit_in) begin
            ones_n = ones_q + OW'(1);
          end
          // clearing wins over span expiry on the same bit
          if (bit_in && (ones_q == ONES_LAST)) begin
            state_n = LS_CLEAR;
            run_n   = '0;
            span_n  = '0;
            ones_n  = '0;
            clr_n   = 1'b1;
          end else if (span_q == SPAN_LAST) begin
            state_n = LS_ARMED;
            span_n  = '0;
            ones_n  = '0;
          end
        end
        default: begin
          state_n = LS_CLEAR;
          run_n   = '0;
          span_n  = '0;
          ones_n  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_CLEAR;
      run_q   <= '0;
      span_q  <= '0;
      ones_q  <= '0;
    end else if (bit_en) begin
      state_q <= state_n;
      run_q   <= run_n;
      span_q  <= span_n;
      ones_q  <= ones_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      set_q <= set_n;
      clr_q <= clr_n;
    end
  end

  assign los_o = (state_q != LS_CLEAR);
  assign set_p = set_q;
  assign clr_p = clr_q;

endmodule

// File: rtl/t1_alarm_mon.sv
module t1_alarm_mon
  import t1_alarm_pkg::*;
#(
  parameter int unsigned WIN_BITS  = T1_WIN_BITS,
  parameter int unsigned MAX_ZEROS = 5,
  parameter int unsigned ZERO_RUN  = 192,
  parameter int unsigned SPAN_BITS = 112,
  parameter int unsigned MIN_ONES  = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic lof_in,
  output logic ais_o,
  output logic ais_set_p,
  output logic ais_clr_p,
  output logic los_o,
  output logic los_set_p,
  output logic los_clr_p
);

  logic rst_int_n;

  t1_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  t1_ais_window #(
    .WIN_BITS  (WIN_BITS),
    .MAX_ZEROS (MAX_ZEROS)
  ) u_ais (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .bit_en  (bit_en),
    .bit_in  (bit_in),
    .qual_in (lof_in),
    .ais_o   (ais_o),
    .set_p   (ais_set_p),
    .clr_p   (ais_clr_p)
  );

  t1_los_detect #(
    .ZERO_RUN  (ZERO_RUN),
    .SPAN_BITS (SPAN_BITS),
    .MIN_ONES  (MIN_ONES)
  ) u_los (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .bit_en (bit_en),
    .bit_in (bit_in),
    .los_o  (los_o),
    .set_p  (los_set_p),
    .clr_p  (los_clr_p)
  );

endmodule

// File: rtl/t1_alarm_mon_chk.sv
module t1_alarm_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic ais_o,
  input logic ais_set_p,
  input logic ais_clr_p,
  input logic los_o,
  input logic los_set_p,
  input logic los_clr_p
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!ais_o && !los_o && !ais_set_p && !ais_clr_p
                               && !los_set_p && !los_clr_p); // R1
    end
  end

  AST_AIS_SET_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ais_set_p |-> (ais_o && !$past(ais_o))); // R3
  AST_AIS_ROSE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ais_o) |-> ais_set_p); // R9
  AST_AIS_CLR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ais_clr_p |-> (!ais_o && $past(ais_o))); // R4
  AST_AIS_FELL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ais_o) |-> ais_clr_p); // R9
  AST_LOS_SET_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    los_set_p |-> (los_o && !$past(los_o))); // R6
  AST_LOS_CLR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    los_clr_p |-> (!los_o && $past(los_o))); // R7
  AST_LOS_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(los_o) |-> los_set_p) and ($fell(los_o) |-> los_clr_p)); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ais_set_p && ais_clr_p) && !(los_set_p && los_clr_p)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> ($stable(ais_o) && $stable(los_o))); // R10
  AST_AIS_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ais_o) |-> $past(bit_en)); // R2

endmodule

bind t1_alarm_mon t1_alarm_mon_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .ais_o     (ais_o),
  .ais_set_p (ais_set_p),
  .ais_clr_p (ais_clr_p),
  .los_o     (los_o),
  .los_set_p (los_set_p),
  .los_clr_p (los_clr_p)
);

// File: tb/t1_alarm_mon_tb.sv
module t1_alarm_mon_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIN = 4632;

  logic clk = 1'b0;
  logic rst_n, bit_en, bit_in, lof_in;
  logic ais_o, ais_set_p, ais_clr_p, los_o, los_set_p, los_clr_p;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  t1_alarm_mon u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .lof_in    (lof_in),
    .ais_o     (ais_o),
    .ais_set_p (ais_set_p),
    .ais_clr_p (ais_clr_p),
    .los_o     (los_o),
    .los_set_p (los_set_p),
    .los_clr_p (los_clr_p)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic send_bit(input logic b);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_n(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic idle(input int n, input logic b);
    bit_en = 1'b0;
    bit_in = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0; lof_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "ais during reset", ais_o, 1'b0);
    chk("R1", "los during reset", los_o, 1'b0);
    rst_n = 1'b1;
    idle(4, 1'b0);
    chk("R1", "ais after reset", ais_o, 1'b0);
    chk("R1", "los after reset", los_o, 1'b0);
    chk("R1", "pulses after reset", ais_set_p | ais_clr_p | los_set_p | los_clr_p, 1'b0);
  endtask

  // one full window: zeros first, then ones; qualifier held for the window
  task automatic t_window(input string req, input int zeros, input logic lof,
                          input logic prev, input logic exp);
    lof_in = lof;
    send_n(1'b0, zeros);
    send_n(1'b1, WIN - 1 - zeros);
    chk("R2", "ais held before window end", ais_o, prev);
    send_bit(1'b1);
    chk(req, "ais at window end", ais_o, exp);
    chk("R9", "ais set pulse", ais_set_p, exp && !prev);
    chk("R9", "ais clear pulse", ais_clr_p, !exp && prev);
    idle(1, 1'b1);
    chk("R9", "ais pulses one cycle", ais_set_p | ais_clr_p, 1'b0);
  endtask

  task automatic t_ais;
    t_window("R3", 5, 1'b1, 1'b0, 1'b1);
    t_window("R4", 6, 1'b1, 1'b1, 1'b0);
    t_window("R5", 0, 1'b0, 1'b0, 1'b0);
    t_window("R3", 0, 1'b1, 1'b0, 1'b1);
    t_window("R5", 0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_los_set;
    send_n(1'b0, 191);
    send_bit(1'b1);
    chk("R6", "191 zeros then one", los_o, 1'b0);
    send_n(1'b0, 100);
    idle(5, 1'b1);
    send_n(1'b0, 91);
    chk("R10", "idle ones ignored, 191 zeros", los_o, 1'b0);
    send_bit(1'b0);
    chk("R6", "los at 192nd zero", los_o, 1'b1);
    chk("R9", "los set pulse", los_set_p, 1'b1);
    idle(1, 1'b1);
    chk("R9", "los set pulse one cycle", los_set_p, 1'b0);
  endtask

  task automatic t_los_rearm;
    send_n(1'b0, 50);
    send_bit(1'b1);
    send_n(1'b1, 12);
    send_n(1'b0, 99);
    chk("R8", "13 ones in span keeps los", los_o, 1'b1);
    send_n(1'b0, 20);
    send_n(1'b1, 13);
    chk("R8", "fresh span, 13 ones", los_o, 1'b1);
    chk("R9", "no clear pulse yet", los_clr_p, 1'b0);
    send_bit(1'b1);
    chk("R7", "14th one clears", los_o, 1'b0);
    chk("R9", "los clear pulse", los_clr_p, 1'b1);
  endtask

  task automatic t_los_edge;
    send_n(1'b0, 192);
    chk("R6", "los set again", los_o, 1'b1);
    send_n(1'b0, 7);
    send_bit(1'b1);
    send_n(1'b1, 12);
    send_n(1'b0, 98);
    chk("R7", "13 ones at bit 111", los_o, 1'b1);
    send_bit(1'b1);
    chk("R7", "14th one on bit 112 clears", los_o, 1'b0);
    chk("R9", "los clear pulse at bit 112", los_clr_p, 1'b1);
  endtask

  initial begin
    t_reset();
    t_ais();
    t_los_set();
    t_los_rearm();
    t_los_edge();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule